// File: doc/BRIEF.md
# Two-Wire Bus Data Flags and Event Clear Logic

This block keeps the status flags for the data path of a two-wire serial bus controller. A single-byte transmit holding register and a single-byte receive holding register sit between the register bus and the bus engine. Three flags track them: transmit-empty, transmit-request and receive-full. Next to them is a set of sticky event flags that the bus engine raises: address match, NACK, stop, bus error, arbitration loss, overrun, and the optional packet-error, timeout and alert flags. Software clears an event flag by writing a one to its bit in a write-one-to-clear register.

Software reaches the block through a plain register port. A write takes effect on the clock edge, and read data is combinational from the address. The engine side gives one-cycle pulses: the engine takes a byte, the engine needs a byte, a received byte is ready, and an event has occurred. The block drives one interrupt line and two DMA request lines. The packet-error, timeout and alert flags exist only when the `SMB_EN` parameter is 1.

Top module: `twi_flag_regs`

## Requirements
- R1: After reset the status register (offset 0x18) reads 0x0001, with only transmit-empty (bit 0) set, and `irq`, `tx_dma_req` and `rx_dma_req` are low.
- R2: A `rx_push` pulse stores `rx_byte` and sets receive-full (status bit 2). A read of the receive data register (offset 0x24) returns that byte and clears the flag. A push in the same cycle as that read leaves the flag set.
- R3: A write to the transmit data register (offset 0x28) clears transmit-empty and drives the byte on `tx_byte`. A `tx_take` pulse sets transmit-empty again. Writing 1 to status bit 0 flushes the holding register to zero and sets transmit-empty.
- R4: A `tx_need` pulse while transmit-empty is set raises transmit-request (status bit 1). A `tx_need` pulse while the holding register is full does not. The next write to the transmit data register clears transmit-request.
- R5: Writing 1 to status bit 1 sets transmit-request only while `nostretch` is 1. While `nostretch` is 0, that write has no effect.
- R6: While `pe` is 0, transmit-empty is held at 1 and transmit-request and receive-full are held at 0.
- R7: Each bit of `ev_set` sets a sticky status flag. Index 0..8 maps to status bits 3, 4, 5, 8, 9, 10, 11, 12, 13 (address match, NACK, stop, bus error, arbitration loss, overrun, packet error, timeout, alert). A flag stays set until it is cleared.
- R8: Writing 1 to a bit of the clear register (offset 0x1C) clears the status flag at the same bit position. Writing 0 has no effect. The clear register always reads as zero.
- R9: When an event pulse and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R10: With `SMB_EN` = 0, status bits 11, 12 and 13 always read 0.
- R11: `irq` is high exactly when some status bit and the same bit of the enable register (offset 0x08) are both 1.
- R12: The control register (offset 0x00) has bit 0 to enable the transmit DMA and bit 1 to enable the receive DMA. `tx_dma_req` follows transmit-request when bit 0 is set. `rx_dma_req` follows receive-full when bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pe | input | 1 | Peripheral enable |
| nostretch | input | 1 | Clock stretching disabled; allows software to set transmit-request |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| tx_take | input | 1 | Engine takes the transmit byte |
| tx_need | input | 1 | Engine needs the next byte |
| tx_byte | output | BW | Transmit holding register contents |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | BW | Received byte |
| ev_set | input | 9 | Event pulses, index order as in R7 |
| irq | output | 1 | Interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The bench walks every event index in turn with only that flag's enable bit set. Per index it applies a zero write, a one write, and a pulse that meets a clear in the same cycle, which separates wrong bit positions, lost stickiness and a reversed set/clear priority. Two builds run side by side with `SMB_EN` at 1 and 0, so the three optional flags must appear in one build and stay at zero in the other. The receive path runs through all 256 byte values. The transmit path is driven through write, take, need, flush and software set, with `nostretch` and `pe` toggled to show the guard and forcing rules.

// File: rtl/twi_flag_regs.sv
module twi_flag_regs #(
  parameter int AW = 6,
  parameter int BW = 8,
  parameter bit SMB_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pe,
  input  logic          nostretch,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          tx_take,
  input  logic          tx_need,
  output logic [BW-1:0] tx_byte,
  input  logic          rx_push,
  input  logic [BW-1:0] rx_byte,
  input  logic [8:0]    ev_set,
  output logic          irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);
  localparam logic [AW-1:0] A_CTRL = AW'(6'h00);
  localparam logic [AW-1:0] A_IER  = AW'(6'h08);
  localparam logic [AW-1:0] A_STS  = AW'(6'h18);
  localparam logic [AW-1:0] A_CLR  = AW'(6'h1C);
  localparam logic [AW-1:0] A_RXD  = AW'(6'h24);
  localparam logic [AW-1:0] A_TXD  = AW'(6'h28);
  localparam logic [8:0] EV_MASK = SMB_EN ? 9'h1FF : 9'h03F;

  logic          txe_q, txis_q, rxne_q;
  logic [8:0]    ev_q;
  logic [13:0]   ier_q;
  logic [1:0]    dma_q;
  logic [BW-1:0] txd_q, rxd_q;
  logic [13:0]   status;

  wire wr_sts = wr_en && addr == A_STS;
  wire wr_clr = wr_en && addr == A_CLR;
  wire wr_txd = wr_en && addr == A_TXD && pe;
  wire rd_rxd = rd_en && addr == A_RXD;
  wire flush  = wr_sts && wdata[0];
  wire sw_txis = wr_sts && wdata[1] && nostretch;
  wire [8:0] clr_vec = wr_clr ? {wdata[13:8], wdata[5:3]} : 9'h0;

  assign status = {ev_q[8:3], 2'b00, ev_q[2:0], rxne_q, txis_q, txe_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q  <= '0;
      ier_q <= '0;
      dma_q <= '0;
    end else begin
      ev_q <= ((ev_q & ~clr_vec) | ev_set) & EV_MASK;
      if (wr_en && addr == A_IER)  ier_q <= wdata[13:0];
      if (wr_en && addr == A_CTRL) dma_q <= wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe_q  <= 1'b1;
      txis_q <= 1'b0;
      txd_q  <= '0;
    end else if (!pe) begin
      txe_q  <= 1'b1;
      txis_q <= 1'b0;
    end else if (wr_txd) begin
      txe_q  <= 1'b0;
      txis_q <= 1'b0;
      txd_q  <= wdata[BW-1:0];
    end else begin
      if (tx_take || flush) txe_q <= 1'b1;
      if (flush) txd_q <= '0;
      if ((tx_need && txe_q) || sw_txis) txis_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxne_q <= 1'b0;
      rxd_q  <= '0;
    end else if (!pe) begin
      rxne_q <= 1'b0;
    end else if (rx_push) begin
      rxne_q <= 1'b1;
      rxd_q  <= rx_byte;
    end else if (rd_rxd) begin
      rxne_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata = {30'b0, dma_q};
      A_IER:   rdata = {18'b0, ier_q};
      A_STS:   rdata = {18'b0, status};
      A_RXD:   rdata = {{(32-BW){1'b0}}, rxd_q};
      A_TXD:   rdata = {{(32-BW){1'b0}}, txd_q};
      default: rdata = '0;
    endcase
  end

  assign tx_byte    = txd_q;
  assign irq        = |(status & ier_q);
  assign tx_dma_req = txis_q && dma_q[0];
  assign rx_dma_req = rxne_q && dma_q[1];
endmodule

// File: rtl/twi_flag_regs_chk.sv
module twi_flag_regs_chk #(
  parameter int AW = 6,
  parameter bit SMB_EN = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pe,
  input logic          nostretch,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic          tx_need,
  input logic          rx_push,
  input logic [8:0]    ev_set,
  input logic          irq,
  input logic          tx_dma_req,
  input logic          txe_q,
  input logic          txis_q,
  input logic          rxne_q,
  input logic [8:0]    ev_q,
  input logic [13:0]   ier_q
);
  localparam logic [8:0] MASK = SMB_EN ? 9'h1FF : 9'h03F;
  localparam logic [AW-1:0] A_CLR = AW'(6'h1C);
  localparam logic [AW-1:0] A_RXD = AW'(6'h24);
  localparam logic [AW-1:0] A_STS = AW'(6'h18);

  // R6
  pe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pe |=> (txe_q && !txis_q && !rxne_q));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |ev_set |=> ((ev_q & $past(ev_set)) == ($past(ev_set) & MASK)));

  // R7
  ev_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_CLR) |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

  // R10
  smb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    SMB_EN || ev_q[8:6] == 3'b000);

  // R2
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_RXD && !rx_push) |=> !rxne_q);

  // R5
  txis_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nostretch && !tx_need && !txis_q && wr_en && addr == A_STS) |=> !txis_q);

  // R12
  tx_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> txis_q);

  // R11
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ier_q != 14'h0));
endmodule

bind twi_flag_regs twi_flag_regs_chk #(.AW(AW), .SMB_EN(SMB_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pe(pe), .nostretch(nostretch), .wr_en(wr_en),
  .rd_en(rd_en), .addr(addr), .tx_need(tx_need), .rx_push(rx_push),
  .ev_set(ev_set), .irq(irq), .tx_dma_req(tx_dma_req), .txe_q(txe_q),
  .txis_q(txis_q), .rxne_q(rxne_q), .ev_q(ev_q), .ier_q(ier_q)
);

// File: tb/test_twi_flag_regs.sv
module test_twi_flag_regs;
  logic clk = 0, rst_n = 0, pe = 0, nostretch = 0, wr_en = 0, rd_en = 0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rd_a, rd_b;
  logic tx_take = 0, tx_need = 0, rx_push = 0;
  logic [7:0] rx_byte = '0, txb_a, txb_b;
  logic [8:0] ev_set = '0;
  logic irq_a, irq_b, txd_a, txd_b, rxd_a, rxd_b;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  twi_flag_regs #(.SMB_EN(1'b1)) i_twi_flag_regs (
    .clk(clk), .rst_n(rst_n), .pe(pe), .nostretch(nostretch), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rd_a), .tx_take(tx_take),
    .tx_need(tx_need), .tx_byte(txb_a), .rx_push(rx_push), .rx_byte(rx_byte),
    .ev_set(ev_set), .irq(irq_a), .tx_dma_req(txd_a), .rx_dma_req(rxd_a));

  twi_flag_regs #(.SMB_EN(1'b0)) i_twi_flag_regs_nosmb (
    .clk(clk), .rst_n(rst_n), .pe(pe), .nostretch(nostretch), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rd_b), .tx_take(tx_take),
    .tx_need(tx_need), .tx_byte(txb_b), .rx_push(rx_push), .rx_byte(rx_byte),
    .ev_set(ev_set), .irq(irq_b), .tx_dma_req(txd_b), .rx_dma_req(rxd_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] va, output logic [31:0] vb);
    @(negedge clk); addr = a; rd_en = 1; #1; va = rd_a; vb = rd_b;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse_ev(input int i);
    @(negedge clk); ev_set = 9'(1 << i);
    @(negedge clk); ev_set = '0;
  endtask

  function automatic int pos(input int i);
    return (i < 3) ? i + 3 : i + 5;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    rd(6'h18, a, b);
    chk("R1 status A", a, 32'h1);
    chk("R1 status B", b, 32'h1);
    chk("R1 outputs", {irq_a, txd_a, rxd_a}, 0);
    rst_n = 1;
    rd(6'h18, a, b);
    chk("R1 status after release", a, 32'h1);
    pe = 1;

    for (int i = 0; i < 9; i++) begin
      logic [31:0] ea, eb;
      ea = 32'h1 | (32'h1 << pos(i));
      eb = (i >= 6) ? 32'h1 : ea;
      wr(6'h08, 32'h1 << pos(i));
      pulse_ev(i);
      rd(6'h18, a, b);
      chk("R7 event set A", a, ea);
      chk("R10 event set B", b, eb);
      chk("R11 irq A", irq_a, 1);
      chk("R11 irq B", irq_b, (i >= 6) ? 0 : 1);
      wr(6'h1C, ~(32'h1 << pos(i)));
      rd(6'h18, a, b);
      chk("R8 clear zero no effect", a, ea);
      rd(6'h1C, a, b);
      chk("R8 clear reads zero", a, 0);
      wr(6'h1C, 32'h1 << pos(i));
      rd(6'h18, a, b);
      chk("R8 cleared A", a, 32'h1);
      chk("R8 cleared B", b, 32'h1);
      chk("R11 irq low", irq_a, 0);
      @(negedge clk); ev_set = 9'(1 << i); addr = 6'h1C; wdata = 32'h1 << pos(i); wr_en = 1;
      @(negedge clk); ev_set = '0; wr_en = 0;
      rd(6'h18, a, b);
      chk("R9 set wins", a, ea);
      wr(6'h1C, 32'h3F38);
    end
    wr(6'h08, 32'h0);

    for (int v = 0; v < 256; v++) begin
      @(negedge clk); rx_byte = 8'(v); rx_push = 1;
      @(negedge clk); rx_push = 0;
      rd(6'h18, a, b);
      chk("R2 rxne set", a, 32'h5);
      rd(6'h24, a, b);
      chk("R2 rx data", a, v);
      rd(6'h18, a, b);
      chk("R2 rxne cleared", a, 32'h1);
    end
    @(negedge clk); rx_byte = 8'h33; rx_push = 1;
    @(negedge clk); addr = 6'h24; rd_en = 1; rx_byte = 8'h44;
    @(negedge clk); rx_push = 0; rd_en = 0;
    rd(6'h18, a, b);
    chk("R2 push beats read", a, 32'h5);
    rd(6'h24, a, b);

    wr(6'h28, 32'hA5);
    rd(6'h18, a, b);
    chk("R3 txe cleared", a, 32'h0);
    chk("R3 tx_byte", txb_a, 8'hA5);
    @(negedge clk); tx_need = 1;
    @(negedge clk); tx_need = 0;
    rd(6'h18, a, b);
    chk("R4 no txis while full", a, 32'h0);
    @(negedge clk); tx_take = 1;
    @(negedge clk); tx_take = 0;
    rd(6'h18, a, b);
    chk("R3 take sets txe", a, 32'h1);
    @(negedge clk); tx_need = 1;
    @(negedge clk); tx_need = 0;
    rd(6'h18, a, b);
    chk("R4 txis set", a, 32'h3);
    wr(6'h00, 32'h1);
    chk("R12 tx dma", txd_a, 1);
    wr(6'h28, 32'h5C);
    rd(6'h18, a, b);
    chk("R4 txis cleared by write", a, 32'h0);
    chk("R12 tx dma low", txd_a, 0);
    wr(6'h18, 32'h1);
    rd(6'h18, a, b);
    chk("R3 flush sets txe", a, 32'h1);
    chk("R3 flush empties", txb_a, 8'h00);

    nostretch = 0;
    wr(6'h18, 32'h2);
    rd(6'h18, a, b);
    chk("R5 sw txis ignored", a, 32'h1);
    nostretch = 1;
    wr(6'h18, 32'h2);
    rd(6'h18, a, b);
    chk("R5 sw txis set", a, 32'h3);

    wr(6'h00, 32'h2);
    @(negedge clk); rx_byte = 8'h11; rx_push = 1;
    @(negedge clk); rx_push = 0;
    chk("R12 rx dma", rxd_a, 1);
    wr(6'h28, 32'h77);
    wr(6'h08, 32'h4);
    chk("R11 rx irq", irq_a, 1);

    @(negedge clk); pe = 0;
    @(negedge clk);
    rd(6'h18, a, b);
    chk("R6 disabled forces", a, 32'h1);
    chk("R6 disabled forces B", b, 32'h1);
    wr(6'h18, 32'h2);
    rd(6'h18, a, b);
    chk("R6 txis held low", a, 32'h1);

    finish_run();
  end
endmodule